// File: doc/BRIEF.md
# Hex Text Record Memory Loader

This block takes a stream of ASCII characters, one per cycle in which `in_valid` is high, and turns text load records into memory writes. A record begins on a header line that holds a four-digit hex load address, a space, a hex byte count of one or more digits, a space, and free text up to the line feed. The data line follows. It holds that many two-digit hex bytes, each followed by a single space, and then free text up to the line feed. Every data byte becomes one write strobe on the memory port, and the address steps up by one for each byte.

Hex digits are decoded over the contiguous character span from `0` to `F`. The seven punctuation characters that sit between `9` and `A` are rejected, as is anything outside the span, including lower-case letters. A bad character in a position that needs a hex digit or a space raises a one-cycle error pulse. The parser then throws characters away until the next line feed and starts a new record after it. A record with a count of zero writes nothing, and its next line is read as a new header.

Top module: `hex_rec_loader`

## Requirements
- R1: A header line starts with exactly four hex digits, most significant first, followed by a space (0x20). The first write of the record goes to that address.
- R2: After the address space comes a count of one or more hex digits, ended by a space. Text after that space is ignored up to the line feed (0x0A), and the data bytes start on the following line.
- R3: Each data byte is two hex digits, high nibble first. It produces exactly one write: `wr_en` is high for one cycle, in the cycle after the low digit is accepted, with `wr_data` holding the byte.
- R4: The bytes of one record go to consecutive addresses, starting at the load address and counting up by one. The 16-bit address wraps from 0xFFFF to 0x0000.
- R5: Every data byte, the last one included, must be followed by a space. After the last byte's space, all characters up to the line feed are ignored and cause no writes and no error, even if they are hex digits or spaces.
- R6: Decoding: 0x30 to 0x39 give 0 to 9 and 0x41 to 0x46 give 10 to 15. The characters 0x3A to 0x40, anything below 0x30 and anything above 0x46 (lower case included) are not hex digits.
- R7: A non-hex character where a hex digit is expected, or any character other than a space where a space is required, makes `err` high for one cycle, in the cycle after that character is accepted. The parser then drops characters up to and including the next line feed and reads a new header after it. If the offending character is itself a line feed, the next character starts a new header.
- R8: A record with a count of zero issues no writes, and the line after its header is parsed as a new header.
- R9: When `in_valid` is low, no character is consumed: `wr_en` and `err` stay low in the next cycle and the parse resumes unchanged.
- R10: A synchronous active-high `rst` drives `wr_en` and `err` low and returns the parser to waiting for the first address digit, even in the middle of a record.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | The character on `in_char` is consumed this cycle |
| in_char | input | 8 | ASCII character |
| wr_en | output | 1 | One-cycle memory write strobe |
| wr_addr | output | 16 | Write address |
| wr_data | output | 8 | Write data byte |
| err | output | 1 | One-cycle malformed-character pulse |

## Verification
Because characters arrive back to back, the write strobe for a byte is on the port in the same cycle that the parser judges the next character, which must be the separating space. The bench sends a record whose second byte follows the first with no space and no idle gap. It then checks that exactly one write comes out, at the load address, and that the error pulse follows that write strobe in the very next cycle, not in the same one. Records sent with idle gaps check that pauses in the stream leave the parse intact.

// File: rtl/hex_rec_loader.sv
module hex_rec_loader #(
  parameter int ADDR_DIGITS = 4,
  parameter int CNT_W       = 16
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     in_valid,
  input  logic [7:0]               in_char,
  output logic                     wr_en,
  output logic [4*ADDR_DIGITS-1:0] wr_addr,
  output logic [7:0]               wr_data,
  output logic                     err
);
  localparam int AW = 4 * ADDR_DIGITS;
  localparam int DW = $clog2(ADDR_DIGITS + 1);

  typedef enum logic [3:0] {
    ST_ADDR = 4'd0, ST_ASP, ST_CNT0, ST_CNT, ST_CMT1,
    ST_DHI, ST_DLO, ST_DSEP, ST_CMT2, ST_SKIP
  } st_t;

  st_t             st, st_n;
  logic [AW-1:0]   addr_q;
  logic [CNT_W-1:0] cnt_q;
  logic [DW-1:0]   dig_q;
  logic [3:0]      hi_q;
  logic            bad, wr_go;

  wire is_dig = (in_char >= 8'h30) && (in_char <= 8'h39);
  wire is_af  = (in_char >= 8'h41) && (in_char <= 8'h46);
  wire hex_ok = is_dig || is_af;
  wire is_sp  = (in_char == 8'h20);
  wire is_lf  = (in_char == 8'h0A);
  wire [3:0] nib = is_af ? in_char[3:0] + 4'd9 : in_char[3:0];
  wire last_dig = (dig_q == DW'(ADDR_DIGITS - 1));

  always_comb begin
    st_n  = st;
    bad   = 1'b0;
    wr_go = 1'b0;
    case (st)
      ST_ADDR:  if (!hex_ok) bad = 1'b1; else if (last_dig) st_n = ST_ASP;
      ST_ASP:   if (!is_sp) bad = 1'b1; else st_n = ST_CNT0;
      ST_CNT0:  if (!hex_ok) bad = 1'b1; else st_n = ST_CNT;
      ST_CNT:   if (is_sp) st_n = ST_CMT1; else if (!hex_ok) bad = 1'b1;
      ST_CMT1:  if (is_lf) st_n = (cnt_q == '0) ? ST_ADDR : ST_DHI;
      ST_DHI:   if (!hex_ok) bad = 1'b1; else st_n = ST_DLO;
      ST_DLO:   if (!hex_ok) bad = 1'b1;
                else begin
                  st_n  = ST_DSEP;
                  wr_go = 1'b1;
                end
      ST_DSEP:  if (!is_sp) bad = 1'b1;
                else st_n = (cnt_q == '0) ? ST_CMT2 : ST_DHI;
      ST_CMT2,
      ST_SKIP:  if (is_lf) st_n = ST_ADDR;
      default:  st_n = ST_ADDR;
    endcase
    if (bad) st_n = is_lf ? ST_ADDR : ST_SKIP;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= ST_ADDR;
      dig_q   <= '0;
      addr_q  <= '0;
      cnt_q   <= '0;
      hi_q    <= '0;
      wr_en   <= 1'b0;
      wr_addr <= '0;
      wr_data <= '0;
      err     <= 1'b0;
    end else begin
      wr_en <= 1'b0;
      err   <= 1'b0;
      if (in_valid) begin
        st    <= st_n;
        err   <= bad;
        wr_en <= wr_go;
        if (st == ST_ADDR && hex_ok) begin
          addr_q <= {addr_q[AW-5:0], nib};
          dig_q  <= last_dig ? '0 : dig_q + DW'(1);
        end
        if (bad) dig_q <= '0;
        if (st == ST_CNT0 && hex_ok) cnt_q <= CNT_W'(nib);
        if (st == ST_CNT && hex_ok) cnt_q <= {cnt_q[CNT_W-5:0], nib};
        if (st == ST_DHI && hex_ok) hi_q <= nib;
        if (wr_go) begin
          wr_addr <= addr_q;
          wr_data <= {hi_q, nib};
          addr_q  <= addr_q + AW'(1);
          cnt_q   <= cnt_q - CNT_W'(1);
        end
      end
    end
  end
endmodule

// File: rtl/hex_rec_loader_chk.sv
module hex_rec_loader_chk #(
  parameter int AW = 16
) (
  input logic          clk,
  input logic          rst,
  input logic          in_valid,
  input logic [7:0]    in_char,
  input logic          wr_en,
  input logic [AW-1:0] wr_addr,
  input logic          err,
  input logic [3:0]    st
);
  logic          seq;
  logic [AW-1:0] last;

  always_ff @(posedge clk) begin
    if (rst) begin
      seq  <= 1'b0;
      last <= '0;
    end else if (wr_en) begin
      seq  <= 1'b1;
      last <= wr_addr;
    end else if (st == 4'd0) begin
      seq <= 1'b0;
    end
  end

  a_r4_addr_step: assert property (@(posedge clk) disable iff (rst)
    (wr_en && seq) |-> (wr_addr == last + AW'(1)));

  a_r3_single_strobe: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> !wr_en);

  a_r7_no_write_with_err: assert property (@(posedge clk) disable iff (rst)
    !(wr_en && err));

  a_r9_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> (!wr_en && !err));

  a_r6_punct_rejected: assert property (@(posedge clk) disable iff (rst)
    (in_valid && st == 4'd0 && in_char >= 8'h3A && in_char <= 8'h40) |=> err);

  a_r10_reset_clear: assert property (@(posedge clk)
    rst |=> (!wr_en && !err));
endmodule

bind hex_rec_loader hex_rec_loader_chk #(.AW(4 * ADDR_DIGITS)) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_char(in_char),
  .wr_en(wr_en), .wr_addr(wr_addr), .err(err), .st(st)
);

// File: tb/tb_hex_rec_loader.sv
`timescale 1ns/1ps
module tb_hex_rec_loader;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [7:0]  in_char = 8'h00;
  logic        wr_en, err;
  logic [15:0] wr_addr;
  logic [7:0]  wr_data;

  int total = 0, bad = 0;
  int err_seen = 0, err_base = 0;
  int cyc = 0, last_wr_cyc = -10, last_err_cyc = -10;
  logic [23:0] exp_q[$];
  logic [23:0] e;

  always #5 clk = ~clk;

  hex_rec_loader dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_char(in_char),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .err(err)
  );

  task automatic chk(input bit ok, input string req, input string msg);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: %s", req, msg);
    end
  endtask

  always @(negedge clk) begin
    cyc++;
    if (!rst) begin
      if (wr_en) begin
        last_wr_cyc = cyc;
        if (exp_q.size() == 0)
          chk(1'b0, "R5", $sformatf("unexpected write got %h=%h exp none", wr_addr, wr_data));
        else begin
          e = exp_q.pop_front();
          chk({wr_addr, wr_data} == e, "R3/R4",
              $sformatf("write got %h=%h exp %h=%h", wr_addr, wr_data, e[23:8], e[7:0]));
        end
      end
      if (err) begin
        err_seen++;
        last_err_cyc = cyc;
      end
    end
  end

  task automatic sendc(input logic [7:0] c, input int gap);
    in_char  = c;
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    repeat (gap) @(negedge clk);
  endtask

  task automatic sends(input string s, input int gap);
    for (int i = 0; i < s.len(); i++) sendc(s[i], gap);
  endtask

  task automatic expw(input logic [15:0] a, input logic [7:0] d);
    exp_q.push_back({a, d});
  endtask

  task automatic settle(input int exp_err, input string req);
    repeat (3) @(negedge clk);
    chk(err_seen - err_base == exp_err, req,
        $sformatf("error pulses got %0d exp %0d", err_seen - err_base, exp_err));
    chk(exp_q.size() == 0, req,
        $sformatf("missing writes got %0d pending exp 0", exp_q.size()));
    err_base = err_seen;
  endtask

  initial begin
    #1_000_000;
    chk(1'b0, "watchdog", "run hung got timeout exp finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R10: outputs low under reset
    chk(!wr_en && !err, "R10", $sformatf("reset outputs got %b%b exp 00", wr_en, err));
    rst = 1'b0;
    @(negedge clk);

    // R1 R2 R3 R4 R5: basic record with trailing comment on both lines
    expw(16'h12AC, 8'hAE); expw(16'h12AD, 8'h03); expw(16'h12AE, 8'hB6);
    expw(16'h12AF, 8'h91); expw(16'h12B0, 8'hC7); expw(16'h12B1, 8'h00);
    expw(16'h12B2, 8'h0C);
    sends("12AC 7 load block\nAE 03 B6 91 C7 00 0C tail text\n", 0);
    settle(0, "R1");

    // R9: idle gaps between every character
    expw(16'h005B, 8'h01); expw(16'h005C, 8'hFC);
    sends("005B 2 x\n01 FC \n", 2);
    settle(0, "R9");

    // R2: multi-digit count and address carry
    for (int i = 0; i < 10; i++) expw(16'h00FB + 16'(i), 8'(8'h10 + i));
    sends("00FB 0A ten\n10 11 12 13 14 15 16 17 18 19 \n", 0);
    settle(0, "R2");

    // R4: wrap from FFFF to 0000
    expw(16'hFFFF, 8'h11); expw(16'h0000, 8'h22);
    sends("FFFF 2 \n11 22 \n", 1);
    settle(0, "R4");

    // R8: zero count, next line is a header
    expw(16'h4000, 8'h5A);
    sends("3000 0 empty\n4000 1 \n5A \n", 0);
    settle(0, "R8");

    // R5: hex digits and spaces inside comments ignored
    expw(16'h8000, 8'h99);
    sends("8000 1 DEAD BEEF\n99 CAFE 12 \n", 0);
    settle(0, "R5");

    // R7: bad address digit, rest of line skipped
    expw(16'h2000, 8'hAB);
    sends("12:4 1 \n2000 1 \nAB \n", 0);
    settle(1, "R7");

    // R6: '@' in a data byte
    expw(16'h6000, 8'h33);
    sends("5000 2 \n1@ 22 \n6000 1 \n33 \n", 0);
    settle(1, "R6");

    // R6: lower case rejected
    expw(16'h6100, 8'h44);
    sends("6100 1 \nab \n6100 1 \n44 \n", 0);
    settle(1, "R6");

    // R7: missing separator, write then error on consecutive cycles
    expw(16'h7000, 8'h11);
    sends("7000 2 \n1122 \n", 0);
    settle(1, "R7");
    chk(last_err_cyc == last_wr_cyc + 1, "R7",
        $sformatf("err cycle got %0d exp %0d", last_err_cyc, last_wr_cyc + 1));

    // R7: line feed as the bad character restarts at once
    expw(16'h9100, 8'h44);
    sends("9000\n9100 1 \n44 \n", 0);
    settle(1, "R7");

    // R6: every punctuation between '9' and 'A', plus '/' and 'G'
    for (int c = 8'h3A; c <= 8'h40; c++) begin
      sendc(8'(c), 0);
      sendc(8'h0A, 0);
    end
    sends("/\nG\n", 0);
    settle(9, "R6");

    // R10: reset mid-record
    sends("12", 0);
    rst = 1'b1;
    @(negedge clk);
    chk(!wr_en && !err, "R10", $sformatf("mid reset got %b%b exp 00", wr_en, err));
    rst = 1'b0;
    @(negedge clk);
    expw(16'h0040, 8'h77);
    sends("0040 1 r\n77 \n", 0);
    settle(0, "R10");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule